// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel that sits beside a timer counter and works in one of two exclusive roles. As an input-capture channel, it picks one of eight input sources, cleans the input with a programmable stability filter, and finds edges of the chosen polarity. On each edge, or on a software strobe, it stores the current counter value. It raises a capture flag, and it raises an over-capture flag when the previous capture has not yet been acknowledged.

As an output-compare channel, it compares the counter against an active compare value and drives an output pin in one of eight waveform modes, with selectable polarity. When preload is enabled, new compare values wait in a shadow register. They become active only on an overflow update, on a match against the old value, or on the software strobe.

Three sticky flags (capture, over-capture, match) each have their own interrupt enable and feed one interrupt line. The counter itself sits outside the block and arrives as `cnt_i`, together with a pulse `ovf_upd_i` for an update that an overflow caused.

Top module: `cc_channel`

## Requirements
- R1: `cap_mode_i`=1 selects capture and 0 selects compare. In capture mode, `oc_o` sits at the inactive level (equal to `oc_pol_i`), compare writes are ignored and no match flag is raised. In compare mode, input edges never capture.
- R2: `edge_sel_i` gives the capture edge of the filtered input: 0 = rising, 1 = falling, 2 or 3 = both.
- R3: A capture loads `cnt_i` into `ccr_o` on the clock edge that sees the event and sets flag bit 0. The event is a qualifying edge, or `sw_gen_i` while in capture mode. A filtered level change becomes an edge one cycle after it appears.
- R4: `src_sel_i` indexes `src_i`. Only the selected bit affects capture.
- R5: Each clock registers the selected input as a sample. The filtered level takes the sample's value once the sample has differed from it on `filt_len_i` consecutive clocks (minimum 1). A value of 0 means the level follows the sample one clock later. A shorter glitch is ignored.
- R6: A capture while flag bit 0 is already set sets flag bit 1 (over-capture).
- R7: `oc_mode_i` codes, each applied at a clock edge: 0 holds, 1 sets on match, 2 clears on match, 3 toggles on match, 4 forces inactive, 5 forces active. A match is `cnt_i` equal to the active compare value; it also sets flag bit 2. `sw_gen_i` in compare mode sets flag bit 2 too.
- R8: Mode 6 drives the reference active when `cnt_i` < compare value, and mode 7 when `cnt_i` >= compare value. The value is registered from the `cnt_i` seen at the edge.
- R9: With `preload_en_i`=0, a compare write becomes the active value on the next edge.
- R10: With `preload_en_i`=1, a write goes to a shadow register. The active value takes the shadow only on `ovf_upd_i`, on a match against the old value, or on `sw_gen_i`.
- R11: `oc_o` = reference XOR `oc_pol_i`, so 1 gives active-low.
- R12: Reset clears `ccr_o`, the flags and the reference. `flag_clr_i` bits clear the matching flags, and a set in the same cycle wins. `irq_o` is the OR of flags ANDed with `irq_en_i`.
- R13: With `chan_en_i`=0, there is no capture, no match and no preload transfer, and the reference returns to inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Timer counter value |
| ovf_upd_i | input | 1 | Update event caused by counter overflow |
| src_i | input | NSRC | Candidate capture inputs |
| sw_gen_i | input | 1 | Software capture/compare strobe |
| chan_en_i | input | 1 | Channel enable |
| cap_mode_i | input | 1 | 1 = capture, 0 = compare |
| src_sel_i | input | SEL_W | Capture source index |
| edge_sel_i | input | 2 | Capture edge select |
| filt_len_i | input | FILT_W | Filter stability length |
| oc_mode_i | input | 3 | Output waveform mode |
| oc_pol_i | input | 1 | Output polarity, 1 = active low |
| preload_en_i | input | 1 | Compare preload enable |
| ccr_wr_i | input | 1 | Compare value write strobe |
| ccr_wdata_i | input | CNT_W | Compare value write data |
| flag_clr_i | input | 3 | Flag clear strobes (0 cap, 1 over, 2 match) |
| irq_en_i | input | 3 | Per-flag interrupt enables |
| oc_o | output | 1 | Compare output pin |
| ccr_o | output | CNT_W | Captured value or active compare value |
| flags_o | output | 3 | Sticky flags (0 cap, 1 over, 2 match) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at the filter edge: a glitch one clock shorter than the programmed length must vanish, while a filter off by one would pass it through or swallow a genuine level. It drives a second capture before the flag is cleared, together with a clear and a set in the same cycle; a wrong priority shows up as a lost capture flag or a missing over-capture flag. It writes compare values with preload on in the middle of a period and then lets a match, an overflow and the strobe each transfer the shadow; a design that loaded early would shift the match point, and its toggle and PWM edges would land in the wrong cycles. Exclusivity is probed by moving the unselected inputs and edges in compare mode; any capture or waveform leaking across would move `ccr_o` or `oc_o`.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [2:0] {
        OC_HOLD       = 3'd0,
        OC_SET_MATCH  = 3'd1,
        OC_CLR_MATCH  = 3'd2,
        OC_TGL_MATCH  = 3'd3,
        OC_FORCE_OFF  = 3'd4,
        OC_FORCE_ON   = 3'd5,
        OC_PWM_BELOW  = 3'd6,
        OC_PWM_ABOVE  = 3'd7
    } oc_mode_e;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'd0,
        EDGE_FALL  = 2'd1,
        EDGE_ANY   = 2'd2,
        EDGE_ANY2  = 2'd3
    } edge_sel_e;

    localparam int NFLAG = 3;

    typedef struct packed {
        logic match;
        logic ovc;
        logic cap;
    } flags_t;

    function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
        case (sel)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            default:   edge_hit = rise | fall;
        endcase
    endfunction

endpackage

// File: rtl/cc_in_filter.sv
module cc_in_filter #(
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raw_i,
    input  logic [FILT_W-1:0] len_i,
    output logic              rise_o,
    output logic              fall_o
);
    logic              smp_q, lvl_q, prv_q;
    logic [FILT_W-1:0] run_q;
    logic [FILT_W:0]   run_nx;

    assign run_nx = {1'b0, run_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= 1'b0;
            lvl_q <= 1'b0;
            prv_q <= 1'b0;
            run_q <= '0;
        end else begin
            smp_q <= raw_i;
            prv_q <= lvl_q;
            if (smp_q == lvl_q) begin
                run_q <= '0;
            end else if (run_nx >= {1'b0, len_i}) begin
                lvl_q <= smp_q;
                run_q <= '0;
            end else begin
                run_q <= run_nx[FILT_W-1:0];
            end
        end
    end

    assign rise_o = lvl_q & ~prv_q;
    assign fall_o = ~lvl_q & prv_q;

    // R5: the filtered level only ever moves to the previous sample value
    p_level_from_sample_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl_q) |-> lvl_q == $past(smp_q));

endmodule

// File: rtl/cc_oc_wave.sv
module cc_oc_wave #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_i,
    input  cc_pkg::oc_mode_e mode_i,
    input  logic             match_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmpv_i,
    input  logic             pol_i,
    output logic             oc_o
);
    import cc_pkg::*;

    logic ref_q, ref_d;

    always_comb begin
        ref_d = ref_q;
        if (!cmp_i) begin
            ref_d = 1'b0;
        end else begin
            case (mode_i)
                OC_HOLD:      ref_d = ref_q;
                OC_SET_MATCH: if (match_i) ref_d = 1'b1;
                OC_CLR_MATCH: if (match_i) ref_d = 1'b0;
                OC_TGL_MATCH: if (match_i) ref_d = ~ref_q;
                OC_FORCE_OFF: ref_d = 1'b0;
                OC_FORCE_ON:  ref_d = 1'b1;
                OC_PWM_BELOW: ref_d = (cnt_i < cmpv_i);
                OC_PWM_ABOVE: ref_d = (cnt_i >= cmpv_i);
                default:      ref_d = ref_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ref_q <= 1'b0;
        else     ref_q <= ref_d;
    end

    assign oc_o = cmp_i ? (ref_q ^ pol_i) : pol_i;

    // R7: forced-active mode leaves the reference active on the next edge
    p_force_on_r7: assert property (@(posedge clk) disable iff (rst)
        (cmp_i && mode_i == OC_FORCE_ON) |=> ref_q);

endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
    parameter int CNT_W  = 16,
    parameter int NSRC   = 8,
    parameter int FILT_W = 8,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CNT_W-1:0]         cnt_i,
    input  logic                     ovf_upd_i,
    input  logic [NSRC-1:0]          src_i,
    input  logic                     sw_gen_i,
    input  logic                     chan_en_i,
    input  logic                     cap_mode_i,
    input  logic [SEL_W-1:0]         src_sel_i,
    input  logic [1:0]               edge_sel_i,
    input  logic [FILT_W-1:0]        filt_len_i,
    input  logic [2:0]               oc_mode_i,
    input  logic                     oc_pol_i,
    input  logic                     preload_en_i,
    input  logic                     ccr_wr_i,
    input  logic [CNT_W-1:0]         ccr_wdata_i,
    input  logic [cc_pkg::NFLAG-1:0] flag_clr_i,
    input  logic [cc_pkg::NFLAG-1:0] irq_en_i,
    output logic                     oc_o,
    output logic [CNT_W-1:0]         ccr_o,
    output logic [cc_pkg::NFLAG-1:0] flags_o,
    output logic                     irq_o
);
    import cc_pkg::*;

    logic             raw_sel, rise, fall;
    logic             cap_ev, cmp_on, match, load_ev;
    logic [CNT_W-1:0] ccr_q, shd_q;
    flags_t           flg_q, clr;

    assign raw_sel = src_i[src_sel_i];

    cc_in_filter #(.FILT_W(FILT_W)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw_sel),
        .len_i  (filt_len_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign cap_ev  = chan_en_i & cap_mode_i &
                     (edge_hit(edge_sel_e'(edge_sel_i), rise, fall) | sw_gen_i);
    assign cmp_on  = chan_en_i & ~cap_mode_i;
    assign match   = cmp_on & (cnt_i == ccr_q);
    assign load_ev = cmp_on & preload_en_i & (ovf_upd_i | match | sw_gen_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q <= '0;
            shd_q <= '0;
        end else begin
            if (cap_ev)
                ccr_q <= cnt_i;
            else if (!cap_mode_i && ccr_wr_i && !preload_en_i)
                ccr_q <= ccr_wdata_i;
            else if (load_ev)
                ccr_q <= shd_q;
            if (!cap_mode_i && ccr_wr_i)
                shd_q <= ccr_wdata_i;
        end
    end

    assign clr = flags_t'(flag_clr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else begin
            flg_q.cap   <= (flg_q.cap & ~clr.cap) | cap_ev;
            flg_q.ovc   <= (flg_q.ovc & ~clr.ovc) | (cap_ev & flg_q.cap);
            flg_q.match <= (flg_q.match & ~clr.match) | match | (cmp_on & sw_gen_i);
        end
    end

    cc_oc_wave #(.CNT_W(CNT_W)) u_wave (
        .clk     (clk),
        .rst     (rst),
        .cmp_i   (cmp_on),
        .mode_i  (oc_mode_e'(oc_mode_i)),
        .match_i (match),
        .cnt_i   (cnt_i),
        .cmpv_i  (ccr_q),
        .pol_i   (oc_pol_i),
        .oc_o    (oc_o)
    );

    assign ccr_o   = ccr_q;
    assign flags_o = flg_q;
    assign irq_o   = |(flg_q & irq_en_i);

    // R3: every capture event leaves the capture flag set
    p_cap_flag_r3: assert property (@(posedge clk) disable iff (rst)
        cap_ev |=> flags_o[0]);

    // R6: capturing over an unacknowledged capture raises over-capture
    p_over_capture_r6: assert property (@(posedge clk) disable iff (rst)
        (cap_ev && flags_o[0]) |=> flags_o[1]);

    // R9: direct write lands on the next edge when preload is off
    p_direct_write_r9: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode_i && ccr_wr_i && !preload_en_i) |=> ccr_o == $past(ccr_wdata_i));

    // R10: with preload on, a write without a transfer event leaves the active value alone
    p_preload_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode_i && preload_en_i && !load_ev) |=> $stable(ccr_o));

endmodule

// File: tb/cc_channel_tb.sv
module cc_channel_tb;
    localparam int CW = 16;
    localparam int CNT_TOP = 39;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cnt_i = '0;
    logic          ovf_upd_i = 1'b0;
    logic [7:0]    src_i = '0;
    logic          sw_gen_i = 1'b0;
    logic          chan_en_i = 1'b1;
    logic          cap_mode_i = 1'b0;
    logic [2:0]    src_sel_i = 3'd5;
    logic [1:0]    edge_sel_i = 2'd0;
    logic [7:0]    filt_len_i = '0;
    logic [2:0]    oc_mode_i = 3'd0;
    logic          oc_pol_i = 1'b0;
    logic          preload_en_i = 1'b0;
    logic          ccr_wr_i = 1'b0;
    logic [CW-1:0] ccr_wdata_i = '0;
    logic [2:0]    flag_clr_i = '0;
    logic [2:0]    irq_en_i = '0;
    logic          oc_o, irq_o;
    logic [CW-1:0] ccr_o;
    logic [2:0]    flags_o;

    cc_channel #(.CNT_W(CW), .NSRC(8), .FILT_W(8)) u_dut (
        .clk(clk), .rst(rst), .cnt_i(cnt_i), .ovf_upd_i(ovf_upd_i), .src_i(src_i),
        .sw_gen_i(sw_gen_i), .chan_en_i(chan_en_i), .cap_mode_i(cap_mode_i),
        .src_sel_i(src_sel_i), .edge_sel_i(edge_sel_i), .filt_len_i(filt_len_i),
        .oc_mode_i(oc_mode_i), .oc_pol_i(oc_pol_i), .preload_en_i(preload_en_i),
        .ccr_wr_i(ccr_wr_i), .ccr_wdata_i(ccr_wdata_i), .flag_clr_i(flag_clr_i),
        .irq_en_i(irq_en_i), .oc_o(oc_o), .ccr_o(ccr_o), .flags_o(flags_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string req   = "R12";
    bit    done  = 0;

    // behavioural reference state
    bit m_smp, m_lvl, m_prv, m_ref, m_fc, m_fo, m_fm;
    int m_run, m_ccr, m_shd;

    // free-running counter stimulus, wraps at CNT_TOP, overflow pulse on the top value
    always @(negedge clk) begin
        cnt_i     <= (cnt_i == CNT_TOP) ? '0 : cnt_i + 1'b1;
        ovf_upd_i <= (cnt_i == CNT_TOP - 1);
    end

    task automatic check(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        bit o_lvl, o_prv, o_smp, o_fc, rise, fall, hit, cap, cmp, mt, ld;
        int o_ccr, o_shd, c;
        cyc++;
        if (rst) begin
            m_smp = 0; m_lvl = 0; m_prv = 0; m_ref = 0; m_fc = 0; m_fo = 0; m_fm = 0;
            m_run = 0; m_ccr = 0; m_shd = 0;
        end else begin
            o_lvl = m_lvl; o_prv = m_prv; o_smp = m_smp; o_fc = m_fc;
            o_ccr = m_ccr; o_shd = m_shd; c = int'(cnt_i);
            rise = o_lvl && !o_prv;
            fall = !o_lvl && o_prv;
            hit  = (edge_sel_i == 0) ? rise : (edge_sel_i == 1) ? fall : (rise || fall);
            cap  = chan_en_i && cap_mode_i && (hit || sw_gen_i);
            cmp  = chan_en_i && !cap_mode_i;
            mt   = cmp && (c == o_ccr);
            ld   = cmp && preload_en_i && (ovf_upd_i || mt || sw_gen_i);
            if (o_smp != o_lvl) begin
                if (m_run + 1 >= int'(filt_len_i)) begin m_lvl = o_smp; m_run = 0; end
                else m_run++;
            end else m_run = 0;
            m_prv = o_lvl;
            m_smp = src_i[src_sel_i];
            if (cap) m_ccr = c;
            else if (!cap_mode_i && ccr_wr_i && !preload_en_i) m_ccr = int'(ccr_wdata_i);
            else if (ld) m_ccr = o_shd;
            if (!cap_mode_i && ccr_wr_i) m_shd = int'(ccr_wdata_i);
            if (!cmp) m_ref = 0;
            else case (oc_mode_i)
                3'd1: if (mt) m_ref = 1;
                3'd2: if (mt) m_ref = 0;
                3'd3: if (mt) m_ref = !m_ref;
                3'd4: m_ref = 0;
                3'd5: m_ref = 1;
                3'd6: m_ref = (c < o_ccr);
                3'd7: m_ref = (c >= o_ccr);
                default: ;
            endcase
            m_fc = (m_fc && !flag_clr_i[0]) || cap;
            m_fo = (m_fo && !flag_clr_i[1]) || (cap && o_fc);
            m_fm = (m_fm && !flag_clr_i[2]) || mt || (cmp && sw_gen_i);
        end
        #2;
        if (!done) begin
            check("oc_o", oc_o, (chan_en_i && !cap_mode_i) ? (m_ref ^ oc_pol_i) : oc_pol_i);
            check("ccr_o", int'(ccr_o), m_ccr);
            check("flags_o", int'(flags_o), {m_fm, m_fo, m_fc});
            check("irq_o", irq_o, |({m_fm, m_fo, m_fc} & irq_en_i));
        end
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_src(bit v);
        src_i = v ? 8'b0010_0000 : 8'b1101_1111;
    endtask

    task automatic write_ccr(int v);
        ccr_wr_i = 1; ccr_wdata_i = CW'(v);
        wait_n(1);
        ccr_wr_i = 0;
    endtask

    task automatic strobe();
        sw_gen_i = 1; wait_n(1); sw_gen_i = 0;
    endtask

    initial begin
        req = "R12";                       // reset state
        wait_n(3);
        rst = 0;
        wait_n(2);

        req = "R9";                        // direct compare writes
        write_ccr(20);
        oc_mode_i = 3'd3;
        wait_n(50);
        write_ccr(7);
        wait_n(45);

        req = "R7";                        // every waveform mode
        write_ccr(10);
        for (int m = 0; m < 6; m++) begin
            oc_mode_i = 3'(m);
            wait_n(47);
        end
        strobe();
        wait_n(3);
        flag_clr_i = 3'b100; wait_n(1); flag_clr_i = 0;

        req = "R8";                        // edge-aligned pulse widths
        oc_mode_i = 3'd6; wait_n(85);
        oc_mode_i = 3'd7; wait_n(85);
        write_ccr(0); wait_n(45);
        write_ccr(CNT_TOP + 1); wait_n(45);

        req = "R11";                       // inverted polarity
        oc_pol_i = 1; write_ccr(15);
        oc_mode_i = 3'd6; wait_n(85);
        oc_pol_i = 0;

        req = "R10";                       // shadowed compare
        preload_en_i = 1;
        oc_mode_i = 3'd3;
        wait_n(5);
        write_ccr(30); wait_n(60);
        write_ccr(5);  wait_n(3); strobe(); wait_n(40);
        write_ccr(33); wait_n(80);
        preload_en_i = 0;

        req = "R1";                        // exclusivity, compare side
        write_ccr(12);
        edge_sel_i = 2'd2;
        for (int i = 0; i < 6; i++) begin put_src(i % 2); wait_n(7); end
        cap_mode_i = 1;                    // capture side: writes ignored, pin idle
        oc_mode_i = 3'd5;
        write_ccr(3); wait_n(4);
        flag_clr_i = 3'b111; wait_n(1); flag_clr_i = 0;

        req = "R2";
        irq_en_i = 3'b001;
        for (int e = 0; e < 3; e++) begin
            edge_sel_i = 2'(e);
            for (int i = 0; i < 4; i++) begin
                put_src(i % 2 == 0); wait_n(9);
                flag_clr_i = 3'b011; wait_n(1); flag_clr_i = 0;
            end
        end

        req = "R4";                        // unselected bits moving alone
        edge_sel_i = 2'd2;
        src_i = 8'b0000_0000; wait_n(6);
        src_i = 8'b1101_1111; wait_n(6);
        src_i = 8'b0000_0000; wait_n(6);
        src_sel_i = 3'd2;
        src_i = 8'b0000_0100; wait_n(6);
        src_i = 8'b0000_0000; wait_n(6);
        src_sel_i = 3'd5;

        req = "R5";                        // filter lengths and glitches
        filt_len_i = 8'd3;
        put_src(1); wait_n(2); put_src(0); wait_n(10);
        put_src(1); wait_n(3); put_src(0); wait_n(10);
        put_src(1); wait_n(8); put_src(0); wait_n(1); put_src(1); wait_n(8);
        filt_len_i = 8'd1;
        put_src(0); wait_n(1); put_src(1); wait_n(6);
        filt_len_i = 8'd0;
        put_src(0); wait_n(5);

        req = "R6";                        // capture over an unacknowledged one
        irq_en_i = 3'b010;
        flag_clr_i = 3'b111; wait_n(1); flag_clr_i = 0;
        put_src(1); wait_n(6); put_src(0); wait_n(6);
        put_src(1); wait_n(6);

        req = "R12";                       // clear racing a set
        irq_en_i = 3'b111;
        put_src(0); wait_n(1);
        flag_clr_i = 3'b011; wait_n(1); flag_clr_i = 0;
        wait_n(6);
        flag_clr_i = 3'b111; wait_n(2); flag_clr_i = 0;

        req = "R3";                        // software capture
        strobe(); wait_n(3); strobe(); wait_n(3);

        req = "R13";                       // disabled channel
        chan_en_i = 0;
        flag_clr_i = 3'b111; wait_n(1); flag_clr_i = 0;
        put_src(1); wait_n(6); strobe(); wait_n(3);
        cap_mode_i = 0; oc_mode_i = 3'd5; wait_n(5);
        preload_en_i = 1; write_ccr(9); strobe(); wait_n(45);
        chan_en_i = 1; wait_n(45);

        done = 1;
        wait_n(1);
        summary();
        $finish;
    end
endmodule